// File: doc/BRIEF.md
# Segmented-Parity and CRC Outer-Coded Polar Encoder

This block turns a fixed-length message into one polar codeword. It protects the message with two outer codes before the inner polar transform. First, the message is cut into equal segments. An even-parity bit is placed right after each segment, so the parity bits are interleaved with the message bits. Second, a 16-bit CRC is computed over that interleaved vector and appended to its end. The combined vector is then written onto the non-frozen positions of an N-bit input vector, and every frozen position is set to zero. Finally, the butterfly transform of the polar kernel is applied in place, one stage per clock.

The block is used as follows. A message is offered on a parallel port with a valid/ready handshake, and the block keeps it until a new one is loaded. A single-cycle start pulse then encodes the held message. The codeword appears on a parallel output and is flagged valid. It stays valid and unchanged until the next message is loaded or the next encoding begins. The same held message may be encoded again with another start pulse.

The controller has five states:
- `ST_EMPTY`: no message held.
- `ST_HELD`: a message is held and waits for start.
- `ST_CRC`: the CRC runs serially, one interleaved bit per clock.
- `ST_XFORM`: one butterfly stage runs per clock.
- `ST_READY`: the codeword is valid.

The transitions are:
- **load**: EMPTY, HELD or READY go to HELD when a message is accepted.
- **go**: HELD or READY go to CRC on start when no message is offered in the same cycle.
- **crc_done**: CRC goes to XFORM after the last interleaved bit.
- **xform_done**: XFORM goes to READY after the last stage.

Top module: `polar_pc_crc_encoder`

## Requirements
- R1: After reset, `cw_valid` is 0, `msg_ready` is 1 and `cw_out` is all zeros.
- R2: A message is accepted on a clock edge where `msg_valid` and `msg_ready` are both 1. `msg_ready` is 1 when no encoding is running (states EMPTY, HELD, READY) and 0 during encoding (CRC, XFORM).
- R3: With segment width S = MSG_W/PAR_CNT, the outer vector w is laid out as follows. For segment s and offset k < S, w[s*(S+1)+k] = msg_in[s*S+k]. The parity bit w[s*(S+1)+S] is the XOR of that segment's S message bits.
- R4: The CRC uses polynomial x^16+x^15+x^2+1 (0x8005) with an all-zero start value and no final inversion. It consumes w[0] first through w[D-1], where D = MSG_W+PAR_CNT. Its remainder is placed as w[D+i] = remainder bit 15-i for i = 0..15.
- R5: Bit w[j] goes to the j-th set bit of `INFO_MASK`, counting from index 0 upward. Positions whose mask bit is 0 carry 0.
- R6: `cw_out[j]` is the XOR of u[i] over all i whose binary index covers the bits of j, that is, (i & j) == j. This is the n-fold Kronecker power of [[1,0],[1,1]].
- R7: `cw_valid` rises exactly D + log2(N) clock edges after the edge that accepts start. With the defaults this is 38 edges.
- R8: While `cw_valid` is 1 and neither `msg_valid` nor `start` is asserted, `cw_valid` stays 1 and `cw_out` stays unchanged. Loading a message clears `cw_valid` on the next edge.
- R9: `start` has no effect while no message is held. `start` and `msg_valid` have no effect during an encoding: the result is the codeword of the message held when the encoding began.
- R10: A start pulse while a codeword is valid re-encodes the held message and produces the same codeword again.
- R11: If `msg_valid` and `start` are both 1 in a cycle where `msg_ready` is 1, the load wins and no encoding starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| msg_in | input | MSG_W | Message; bit 0 is the first message bit |
| msg_valid | input | 1 | Message offered |
| msg_ready | output | 1 | Block can accept a message |
| start | input | 1 | One-cycle request to encode the held message |
| cw_out | output | N | Codeword; index j is codeword bit j |
| cw_valid | output | 1 | `cw_out` holds a finished codeword |

## Verification
Most internal faults show up at the codeword, but in different ways:
- A parity bit placed one position off, a wrong CRC tap or a mis-ranked mask position changes `cw_out` in an input-dependent pattern. Messages with single bits set, all ones and mixed values are therefore compared against an independently computed codeword as soon as `cw_valid` rises.
- A miscounted stage or CRC step moves the rise of `cw_valid` by whole cycles. The latency is therefore measured edge by edge from the accepting edge.
- A state that leaks out of encoding shows up one cycle later as `msg_ready` or `cw_valid` at the wrong level.
- A held codeword that drifts is caught by watching it across idle cycles.

// File: rtl/pcpe_pkg.sv
package pcpe_pkg;

    typedef enum logic [2:0] {
        ST_EMPTY,
        ST_HELD,
        ST_CRC,
        ST_XFORM,
        ST_READY
    } enc_state_t;

    localparam int          CRC_W    = 16;
    localparam logic [15:0] CRC_POLY = 16'h8005;

endpackage

// File: rtl/pcpe_parity.sv
module pcpe_parity #(
    parameter int MSG_W   = 24,
    parameter int PAR_CNT = 8
) (
    input  logic [MSG_W-1:0]         msg,
    output logic [MSG_W+PAR_CNT-1:0] pre
);
    localparam int SEG_W = MSG_W / PAR_CNT;

    // Each segment is copied and followed by its own even-parity bit.
    for (genvar s = 0; s < PAR_CNT; s++) begin : g_seg
        assign pre[s*(SEG_W+1) +: SEG_W] = msg[s*SEG_W +: SEG_W];
        assign pre[s*(SEG_W+1) + SEG_W]  = ^msg[s*SEG_W +: SEG_W];
    end
endmodule

// File: rtl/pcpe_crc16.sv
module pcpe_crc16
    import pcpe_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             shift,
    input  logic             din,
    output logic [CRC_W-1:0] crc_next
);
    logic [CRC_W-1:0] crc_q;
    logic             fb;

    // One bit per clock, first bit first.
    always_comb begin
        fb       = din ^ crc_q[CRC_W-1];
        crc_next = {crc_q[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            crc_q <= '0;
        else if (clear)
            crc_q <= '0;
        else if (shift)
            crc_q <= crc_next;
    end
endmodule

// File: rtl/pcpe_mapper.sv
module pcpe_mapper #(
    parameter int             N         = 64,
    parameter int             K         = 48,
    parameter logic [N-1:0]   INFO_MASK = '1
) (
    input  logic [K-1:0] w,
    output logic [N-1:0] u
);
    // Rank of a position among the non-frozen positions below it.
    function automatic int rank_of(input int idx);
        int r;
        r = 0;
        for (int b = 0; b < idx; b++)
            if (INFO_MASK[b]) r++;
        return r;
    endfunction

    for (genvar gi = 0; gi < N; gi++) begin : g_pos
        if (INFO_MASK[gi]) begin : g_info
            assign u[gi] = w[rank_of(gi)];
        end else begin : g_frozen
            assign u[gi] = 1'b0;
        end
    end
endmodule

// File: rtl/pcpe_butterfly.sv
module pcpe_butterfly #(
    parameter int N = 64
) (
    input  logic [N-1:0]               v_in,
    input  logic [$clog2($clog2(N)+1)-1:0] stage_sel,
    output logic [N-1:0]               v_out
);
    localparam int STAGES = $clog2(N);
    localparam int SEL_W  = $clog2(STAGES+1);

    logic [N-1:0] cand [STAGES];

    // Stage s folds the upper partner (span 2^s) into each lower position.
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        for (genvar i = 0; i < N; i++) begin : g_bit
            if (((i >> s) & 1) == 0) begin : g_lo
                assign cand[s][i] = v_in[i] ^ v_in[i + (1 << s)];
            end else begin : g_hi
                assign cand[s][i] = v_in[i];
            end
        end
    end

    always_comb begin
        v_out = v_in;
        for (int s = 0; s < STAGES; s++)
            if (stage_sel == SEL_W'(s)) v_out = cand[s];
    end
endmodule

// File: rtl/polar_pc_crc_encoder.sv
module polar_pc_crc_encoder
    import pcpe_pkg::*;
#(
    parameter int           N         = 64,
    parameter int           MSG_W     = 24,
    parameter int           PAR_CNT   = 8,
    parameter logic [N-1:0] INFO_MASK = 64'hFFFF_FFFF_FEE8_E880
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [MSG_W-1:0] msg_in,
    input  logic             msg_valid,
    output logic             msg_ready,
    input  logic             start,
    output logic [N-1:0]     cw_out,
    output logic             cw_valid
);
    localparam int PRE_W  = MSG_W + PAR_CNT;
    localparam int K      = PRE_W + CRC_W;
    localparam int STAGES = $clog2(N);
    localparam int SEL_W  = $clog2(STAGES+1);
    localparam int CNT_W  = $clog2(PRE_W+1);
    localparam logic [CNT_W-1:0] LAST_BIT   = CNT_W'(PRE_W-1);
    localparam logic [CNT_W-1:0] LAST_STAGE = CNT_W'(STAGES-1);

    enc_state_t        state_q, state_d;
    logic [MSG_W-1:0]  msg_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [N-1:0]      u_q;

    logic              load_acc, go;
    logic              crc_clear, crc_shift, crc_last, xf_last;
    logic [PRE_W-1:0]  pre;
    logic              crc_din;
    logic [CRC_W-1:0]  crc_next;
    logic [K-1:0]      w_full;
    logic [N-1:0]      u_map;
    logic [N-1:0]      u_stage;

    // ---------------- outer layer 1: segment parity ----------------
    pcpe_parity #(.MSG_W(MSG_W), .PAR_CNT(PAR_CNT)) u_parity (
        .msg (msg_q),
        .pre (pre)
    );

    // serial pick of the interleaved bit addressed by the counter
    always_comb begin
        crc_din = 1'b0;
        for (int i = 0; i < PRE_W; i++)
            if (cnt_q == CNT_W'(i)) crc_din = pre[i];
    end

    // ---------------- outer layer 2: CRC ----------------
    pcpe_crc16 u_crc (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (crc_clear),
        .shift    (crc_shift),
        .din      (crc_din),
        .crc_next (crc_next)
    );

    // remainder appended highest-order bit first
    assign w_full[PRE_W-1:0] = pre;
    for (genvar i = 0; i < CRC_W; i++) begin : g_rem
        assign w_full[PRE_W+i] = crc_next[CRC_W-1-i];
    end

    // ---------------- placement and inner transform ----------------
    pcpe_mapper #(.N(N), .K(K), .INFO_MASK(INFO_MASK)) u_mapper (
        .w (w_full),
        .u (u_map)
    );

    pcpe_butterfly #(.N(N)) u_bfly (
        .v_in      (u_q),
        .stage_sel (cnt_q[SEL_W-1:0]),
        .v_out     (u_stage)
    );

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_EMPTY;
        else
            state_q <= state_d;
    end

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: if (msg_valid) state_d = ST_HELD;
            ST_HELD,
            ST_READY: begin
                if (msg_valid)  state_d = ST_HELD;   // load
                else if (start) state_d = ST_CRC;    // go
            end
            ST_CRC:   if (cnt_q == LAST_BIT)   state_d = ST_XFORM;   // crc_done
            ST_XFORM: if (cnt_q == LAST_STAGE) state_d = ST_READY;   // xform_done
            default:  state_d = ST_EMPTY;
        endcase
    end

    // ---------------- outputs and controls ----------------
    always_comb begin
        msg_ready = 1'b0;
        cw_valid  = 1'b0;
        crc_shift = 1'b0;
        crc_last  = 1'b0;
        xf_last   = 1'b0;
        unique case (state_q)
            ST_EMPTY: msg_ready = 1'b1;
            ST_HELD:  msg_ready = 1'b1;
            ST_READY: begin
                msg_ready = 1'b1;
                cw_valid  = 1'b1;
            end
            ST_CRC: begin
                crc_shift = 1'b1;
                crc_last  = (cnt_q == LAST_BIT);
            end
            ST_XFORM: xf_last = (cnt_q == LAST_STAGE);
            default: ;
        endcase
        load_acc  = msg_valid & msg_ready;
        go        = start & ~msg_valid & (state_q == ST_HELD || state_q == ST_READY);
        crc_clear = go;
    end

    assign cw_out = u_q;

    // ---------------- datapath ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            msg_q <= '0;
            cnt_q <= '0;
            u_q   <= '0;
        end else begin
            if (load_acc)
                msg_q <= msg_in;
            if (go) begin
                cnt_q <= '0;
            end else if (crc_shift) begin
                if (crc_last) begin
                    cnt_q <= '0;
                    u_q   <= u_map;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end else if (state_q == ST_XFORM) begin
                u_q   <= u_stage;
                cnt_q <= xf_last ? '0 : cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/pcpe_checker.sv
module pcpe_checker
    import pcpe_pkg::*;
#(
    parameter int N   = 64,
    parameter int LAT = 38
) (
    input logic       clk,
    input logic       rst_n,
    input logic       msg_valid,
    input logic       msg_ready,
    input logic       start,
    input logic       cw_valid,
    input logic [N-1:0] cw_out,
    input enc_state_t enc_state
);
    logic [15:0] lat_q;
    logic        busy;

    assign busy = (enc_state == ST_CRC) || (enc_state == ST_XFORM);

    // edges elapsed since the accepting edge, counted while encoding
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            lat_q <= '0;
        else if (start && !msg_valid && (enc_state == ST_HELD || enc_state == ST_READY))
            lat_q <= '0;
        else if (busy)
            lat_q <= lat_q + 16'd1;
    end

    assert_busy_closed_R2: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (!msg_ready && !cw_valid));

    assert_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cw_valid) |-> (lat_q == 16'(LAT)));

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cw_valid && !msg_valid && !start) |=> (cw_valid && $stable(cw_out)));

    assert_load_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cw_valid && msg_valid) |=> !cw_valid);

    assert_empty_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (enc_state == ST_EMPTY && !msg_valid) |=> (enc_state == ST_EMPTY));

    assert_load_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_ready && msg_valid && start) |=> (enc_state == ST_HELD));
endmodule

bind polar_pc_crc_encoder pcpe_checker #(
    .N   (N),
    .LAT (MSG_W + PAR_CNT + $clog2(N))
) u_pcpe_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .msg_valid (msg_valid),
    .msg_ready (msg_ready),
    .start     (start),
    .cw_valid  (cw_valid),
    .cw_out    (cw_out),
    .enc_state (state_q)
);

// File: tb/polar_pc_crc_encoder_test.sv
`timescale 1ns/1ps
module polar_pc_crc_encoder_test;
    localparam int           N     = 64;
    localparam int           M     = 24;
    localparam int           P     = 8;
    localparam int           S     = M / P;
    localparam int           D     = M + P;
    localparam int           K     = D + 16;
    localparam int           LAT   = D + 6;
    localparam logic [N-1:0] MASK  = 64'hFFFF_FFFF_FEE8_E880;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [M-1:0] msg_in = '0;
    logic         msg_valid = 1'b0;
    logic         start = 1'b0;
    logic         msg_ready;
    logic [N-1:0] cw_out;
    logic         cw_valid;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;   // 250 MHz

    polar_pc_crc_encoder uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .msg_in    (msg_in),
        .msg_valid (msg_valid),
        .msg_ready (msg_ready),
        .start     (start),
        .cw_out    (cw_out),
        .cw_valid  (cw_valid)
    );

    // Independent model: interleave, CRC by long division, place, covering-index XOR.
    function automatic logic [N-1:0] model_cw(input logic [M-1:0] m);
        logic [K-1:0]    w;
        logic [D+15:0]   arr;
        logic [N-1:0]    u, x;
        logic            p;
        int              j;
        w = '0;
        for (int s = 0; s < P; s++) begin
            p = 1'b0;
            for (int k = 0; k < S; k++) begin
                w[s*(S+1)+k] = m[s*S+k];
                p = p ^ m[s*S+k];
            end
            w[s*(S+1)+S] = p;
        end
        arr = '0;
        for (int i = 0; i < D; i++) arr[i] = w[i];
        for (int i = 0; i < D; i++) begin
            if (arr[i]) begin
                arr[i]    = ~arr[i];     // x^16 term
                arr[i+1]  = ~arr[i+1];   // x^15 term
                arr[i+14] = ~arr[i+14];  // x^2 term
                arr[i+16] = ~arr[i+16];  // x^0 term
            end
        end
        for (int i = 0; i < 16; i++) w[D+i] = arr[D+i];
        j = 0;
        for (int i = 0; i < N; i++) begin
            if (MASK[i]) begin
                u[i] = w[j];
                j++;
            end else begin
                u[i] = 1'b0;
            end
        end
        for (int jj = 0; jj < N; jj++) begin
            x[jj] = 1'b0;
            for (int i = 0; i < N; i++)
                if ((i & jj) == jj) x[jj] = x[jj] ^ u[i];
        end
        return x;
    endfunction

    task automatic check_bit(input logic act, input logic exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0b expected=%0b", what, act, exp);
        end
    endtask

    task automatic check_cw(input logic [N-1:0] act, input logic [N-1:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", what, act, exp);
        end
    endtask

    task automatic check_int(input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic load_msg(input logic [M-1:0] m);
        @(negedge clk);
        msg_in    = m;
        msg_valid = 1'b1;
        @(negedge clk);
        msg_valid = 1'b0;
    endtask

    task automatic pulse_start();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_valid(output bit ok);
        int n;
        n = 0;
        while (!cw_valid && n < 200) begin
            @(negedge clk);
            n++;
        end
        ok = cw_valid;
    endtask

    task automatic t_reset_R1();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_bit(cw_valid, 1'b0, "R1 cw_valid after reset");
        check_bit(msg_ready, 1'b1, "R1 msg_ready after reset");
        check_cw(cw_out, '0, "R1 cw_out after reset");
    endtask

    task automatic t_idle_start_R9();
        pulse_start();
        repeat (LAT + 5) @(negedge clk);
        check_bit(cw_valid, 1'b0, "R9 start with no message held");
        check_bit(msg_ready, 1'b1, "R9 still ready after idle start");
    endtask

    task automatic t_encode(input logic [M-1:0] m, input string tag);
        bit ok;
        load_msg(m);
        pulse_start();
        wait_valid(ok);
        check_bit(ok, 1'b1, {tag, " codeword produced"});
        check_cw(cw_out, model_cw(m), {tag, " R3/R4/R5/R6 codeword"});
    endtask

    task automatic t_latency_R7();
        int n;
        load_msg(24'h5A5A5A);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);          // accepting edge has passed
        start = 1'b0;
        check_bit(msg_ready, 1'b0, "R2 msg_ready low during encoding");
        check_bit(cw_valid, 1'b0, "R2 cw_valid low during encoding");
        n = 0;
        while (!cw_valid && n < 200) begin
            @(negedge clk);
            n++;
        end
        check_int(n, LAT, "R7 edges from accept to cw_valid");
        check_cw(cw_out, model_cw(24'h5A5A5A), "R7 codeword after latency");
    endtask

    task automatic t_hold_R8();
        logic [N-1:0] keep;
        keep = cw_out;
        repeat (20) @(negedge clk);
        check_bit(cw_valid, 1'b1, "R8 cw_valid held while idle");
        check_cw(cw_out, keep, "R8 cw_out stable while idle");
        @(negedge clk);
        msg_in    = 24'h000F00;
        msg_valid = 1'b1;
        @(negedge clk);
        msg_valid = 1'b0;
        check_bit(cw_valid, 1'b0, "R8 cw_valid cleared by load");
    endtask

    task automatic t_busy_ignore_R9();
        bit ok;
        load_msg(24'h3C3C3C);
        pulse_start();
        msg_in    = 24'hFFFF00;
        msg_valid = 1'b1;
        start     = 1'b1;
        repeat (5) @(negedge clk);
        msg_valid = 1'b0;
        start     = 1'b0;
        wait_valid(ok);
        check_bit(ok, 1'b1, "R9 encoding completes despite busy inputs");
        check_cw(cw_out, model_cw(24'h3C3C3C), "R9 busy load/start ignored");
    endtask

    task automatic t_reencode_R10();
        bit ok;
        logic [N-1:0] first;
        first = cw_out;
        pulse_start();
        check_bit(cw_valid, 1'b0, "R10 valid drops on re-encode");
        wait_valid(ok);
        check_cw(cw_out, first, "R10 re-encode gives same codeword");
    endtask

    task automatic t_load_wins_R11();
        bit ok;
        @(negedge clk);
        msg_in    = 24'h00C0DE;
        msg_valid = 1'b1;
        start     = 1'b1;
        @(negedge clk);
        msg_valid = 1'b0;
        start     = 1'b0;
        repeat (LAT + 5) @(negedge clk);
        check_bit(cw_valid, 1'b0, "R11 no encoding when load and start coincide");
        pulse_start();
        wait_valid(ok);
        check_cw(cw_out, model_cw(24'h00C0DE), "R11 new message was loaded");
    endtask

    initial begin
        #2_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog expired: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_reset_R1();
        t_idle_start_R9();
        t_encode(24'h000000, "zero");
        t_encode(24'h000001, "first bit");
        t_encode(24'h800000, "last bit");
        t_encode(24'h000004, "segment end bit");
        t_encode(24'hFFFFFF, "all ones");
        t_encode(24'hA5C3F0, "mixed A");
        t_encode(24'h123456, "mixed B");
        t_latency_R7();
        t_reencode_R10();
        t_hold_R8();
        t_busy_ignore_R9();
        t_load_wins_R11();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule